// File: doc/BRIEF.md
# Cache Line Fill Qualifier

This block watches the read cycles that a processor bus unit issues and decides, transfer by transfer, whether a read turns into a multi-transfer cache line fill. It also decides whether the line that was fetched may be stored in the on-chip cache.

The active-low cache-enable input is meaningful only in the clock just before a ready. Either the single-transfer ready or the burst ready counts as a ready. The value seen before the first ready decides whether the read becomes a fill. The value seen before the last ready of the fill decides whether the line is committed.

The block also latches the page write-through and page cache-disable attribute pins at the start of each accepted cycle. These pins are forced low when paging is off, and the cache-disable pin is suppressed by a control-register cache-disable bit. A separate path synchronises an active-low, possibly one-clock, flush input and produces a single-clock request to invalidate the whole cache.

The controller is a three-state machine:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No cycle is in progress. |
| `ST_FIRST` | A cycle has been accepted and is waiting for its first ready. |
| `ST_BURST` | A line fill is collecting its remaining transfers. |

Its transitions are:

| Transition | Condition |
|------------|-----------|
| `ST_IDLE` to `ST_FIRST` | `cyc_start` is high. |
| `ST_FIRST` to `ST_BURST` | A ready arrives, the cycle is cacheable, and cache-enable was low in the clock before. |
| `ST_FIRST` to `ST_IDLE` | A ready arrives and the read is not a fill. |
| `ST_BURST` to `ST_BURST` | An intermediate ready arrives; the beat count advances. |
| `ST_BURST` to `ST_IDLE` | The final ready arrives; the commit decision is made. |

Top module: `cfq_line_fill_qual`

## Requirements
- R1: `line_fill` rises after the clock edge of the first ready of an accepted cycle if and only if the cycle is cacheable (R4) and `ken_n` was 0 at the clock edge immediately before that ready edge. Otherwise `line_fill` stays 0 and the cycle ends as a single transfer.
- R2: Once raised, `line_fill` stays 1 through the intermediate transfers. It falls after the edge of the BEATS-th ready (default 4) counted from the first ready.
- R3: `line_commit` is a one-clock pulse that follows the edge of the final ready of a fill. It is 1 exactly when `ken_n` was 0 at the edge before that final ready. It is never 1 for a cycle that did not become a fill.
- R4: An accepted cycle is cacheable when `cyc_cacheable` is 1, `cr_cd` is 0, and not both `paging_en` and `page_pcd` are 1. These values are sampled at the accepting edge, so `page_pcd` has no effect on cacheability while paging is off.
- R5: From the accepting edge onward, `pwt_o` equals `paging_en & page_pwt` as sampled at that edge.
- R6: From the accepting edge onward, `pcd_o` equals `paging_en & page_pcd & ~cr_cd` as sampled at that edge.
- R7: `attr_oe` is 0 whenever `bus_hold` is 1 and 1 otherwise, in the same clock.
- R8: Each high-to-low transition of `flush_n` produces exactly one `flush_req` pulse of one clock. The pulse is visible after the second rising edge at which `flush_n` is sampled low, however long `flush_n` then stays low.
- R9: `cyc_start` is ignored while a cycle is in progress. It changes neither `pwt_o`/`pcd_o` nor the fill sequence.
- R10: A ready is `rdy_n == 0` or `brdy_n == 0`. Either one, or both together, advances a transfer in the same way.
- R11: After reset, `line_fill`, `line_commit`, `flush_req`, `pwt_o` and `pcd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse when a read cycle begins |
| cyc_cacheable | input | 1 | The cycle is eligible for caching |
| ken_n | input | 1 | Active-low cache enable |
| rdy_n | input | 1 | Active-low single-transfer ready |
| brdy_n | input | 1 | Active-low burst ready |
| paging_en | input | 1 | Address translation is enabled |
| page_pwt | input | 1 | Write-through attribute of the current page |
| page_pcd | input | 1 | Cache-disable attribute of the current page |
| cr_cd | input | 1 | Control-register cache-disable bit |
| bus_hold | input | 1 | Bus hold: the attribute pins must float |
| flush_n | input | 1 | Active-low asynchronous cache flush |
| line_fill | output | 1 | The current read is a line fill |
| line_commit | output | 1 | One-clock strobe to store the filled line |
| pwt_o | output | 1 | Page write-through pin value |
| pcd_o | output | 1 | Page cache-disable pin value |
| attr_oe | output | 1 | Drive enable for `pwt_o` and `pcd_o` |
| flush_req | output | 1 | One-clock whole-cache invalidate request |

## Verification
The assertions rely on the bus unit never returning a ready in the clock that carries `cyc_start` and never returning one while the controller is idle. They also rely on `cyc_start` being a single-clock pulse. The bench keeps to these rules by building every transfer as zero to two idle clocks, then a clock that presents the intended cache-enable value, then one ready clock. The ready form (single, burst or both) is chosen at random, and cache-enable is random on every clock whose value must not matter. Extra start pulses are injected only while a fill is in progress, to show that they are ignored.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BURST = 2'd2
    } fill_state_t;
endpackage

// File: rtl/cfq_flush_sync.sv
module cfq_flush_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_n,
    output logic flush_req
);
    // chain[0..STAGES-1] synchronise; chain[STAGES] keeps the previous synced value
    logic [STAGES:0] chain;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= flush_n;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign flush_req = chain[STAGES] & ~chain[STAGES-1];

    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req); // R8
endmodule

// File: rtl/cfq_page_attr.sv
module cfq_page_attr (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic paging_en,
    input  logic page_pwt,
    input  logic page_pcd,
    input  logic cr_cd,
    input  logic bus_hold,
    output logic cache_inhibit,
    output logic pwt_o,
    output logic pcd_o,
    output logic attr_oe
);
    logic pwt_q, pcd_q;

    // translation attributes only count while paging is on
    logic pwt_eff, pcd_page;
    assign pwt_eff  = paging_en & page_pwt;
    assign pcd_page = paging_en & page_pcd;

    assign cache_inhibit = cr_cd | pcd_page;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwt_q <= 1'b0;
            pcd_q <= 1'b0;
        end else if (load) begin
            pwt_q <= pwt_eff;
            pcd_q <= pcd_page & ~cr_cd;
        end
    end

    assign pwt_o   = pwt_q;
    assign pcd_o   = pcd_q;
    assign attr_oe = ~bus_hold;

    AST_PAGING_OFF_PWT: assert property (@(posedge clk) disable iff (!rst_n)
        load && !paging_en |=> !pwt_o && !pcd_o); // R5
    AST_CD_MASKS_PCD: assert property (@(posedge clk) disable iff (!rst_n)
        load && cr_cd |=> !pcd_o); // R6
    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pwt_o) && $stable(pcd_o)); // R9
endmodule

// File: rtl/cfq_fill_fsm.sv
module cfq_fill_fsm
    import cfq_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic cyc_cacheable,
    input  logic cache_inhibit,
    input  logic ken_n,
    input  logic rdy_any,
    output logic start_accept,
    output logic line_fill,
    output logic line_commit
);
    localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    fill_state_t      state_q, state_d;
    logic [CNT_W-1:0] beat_q, beat_d;
    logic             cach_q, cach_d;
    logic             commit_q, commit_d;
    logic             ken_q;

    // cache enable as seen one clock earlier
    always_ff @(posedge clk) begin
        if (!rst_n) ken_q <= 1'b0;
        else        ken_q <= ~ken_n;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            cach_q   <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            beat_q   <= beat_d;
            cach_q   <= cach_d;
            commit_q <= commit_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        beat_d   = beat_q;
        cach_d   = cach_q;
        commit_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_start) begin
                    state_d = ST_FIRST;
                    cach_d  = cyc_cacheable & ~cache_inhibit;
                end
            end
            ST_FIRST: begin
                if (rdy_any) begin
                    if (cach_q && ken_q) begin
                        state_d = ST_BURST;
                        beat_d  = CNT_W'(1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BURST: begin
                if (rdy_any) begin
                    if (beat_q == LAST_BEAT) begin
                        state_d  = ST_IDLE;
                        beat_d   = '0;
                        commit_d = ken_q;
                    end else begin
                        beat_d = beat_q + CNT_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_accept = (state_q == ST_IDLE) && cyc_start;
        line_fill    = (state_q == ST_BURST);
        line_commit  = commit_q;
    end

    AST_FILL_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_fill) |-> $past(rdy_any)); // R1
    AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        line_fill && !rdy_any |=> line_fill); // R2
    AST_COMMIT_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        line_commit |-> $past(line_fill)); // R3
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_commit |=> !line_commit); // R3
    AST_NO_ACCEPT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        line_fill |-> !start_accept); // R9
endmodule

// File: rtl/cfq_line_fill_qual.sv
module cfq_line_fill_qual #(
    parameter int BEATS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic cyc_cacheable,
    input  logic ken_n,
    input  logic rdy_n,
    input  logic brdy_n,
    input  logic paging_en,
    input  logic page_pwt,
    input  logic page_pcd,
    input  logic cr_cd,
    input  logic bus_hold,
    input  logic flush_n,
    output logic line_fill,
    output logic line_commit,
    output logic pwt_o,
    output logic pcd_o,
    output logic attr_oe,
    output logic flush_req
);
    logic rdy_any;
    logic start_accept;
    logic cache_inhibit;

    assign rdy_any = ~rdy_n | ~brdy_n; // R10

    cfq_page_attr u_attr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (start_accept),
        .paging_en    (paging_en),
        .page_pwt     (page_pwt),
        .page_pcd     (page_pcd),
        .cr_cd        (cr_cd),
        .bus_hold     (bus_hold),
        .cache_inhibit(cache_inhibit),
        .pwt_o        (pwt_o),
        .pcd_o        (pcd_o),
        .attr_oe      (attr_oe)
    );

    cfq_fill_fsm #(.BEATS(BEATS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start    (cyc_start),
        .cyc_cacheable(cyc_cacheable),
        .cache_inhibit(cache_inhibit),
        .ken_n        (ken_n),
        .rdy_any      (rdy_any),
        .start_accept (start_accept),
        .line_fill    (line_fill),
        .line_commit  (line_commit)
    );

    cfq_flush_sync #(.STAGES(SYNC_STAGES)) u_flush (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_n  (flush_n),
        .flush_req(flush_req)
    );

    AST_OE_FOLLOWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> !attr_oe); // R7
endmodule

// File: tb/cfq_line_fill_qual_tb.sv
module cfq_line_fill_qual_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic cyc_start, cyc_cacheable, ken_n, rdy_n, brdy_n;
    logic paging_en, page_pwt, page_pcd, cr_cd, bus_hold, flush_n;
    logic line_fill, line_commit, pwt_o, pcd_o, attr_oe, flush_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    cfq_line_fill_qual u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_cacheable(cyc_cacheable),
        .ken_n(ken_n), .rdy_n(rdy_n), .brdy_n(brdy_n), .paging_en(paging_en),
        .page_pwt(page_pwt), .page_pcd(page_pcd), .cr_cd(cr_cd), .bus_hold(bus_hold),
        .flush_n(flush_n), .line_fill(line_fill), .line_commit(line_commit),
        .pwt_o(pwt_o), .pcd_o(pcd_o), .attr_oe(attr_oe), .flush_req(flush_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_cacheable(bit c, bit pg, bit pcd, bit cd);
        return c && !cd && !(pg && pcd);
    endfunction

    // one transfer: idle clocks, a clock that sets cache enable, a ready clock
    task automatic xfer(input bit ken_on);
        int w;
        int kind;
        w = $urandom_range(0, 2);
        for (int i = 0; i < w; i++) begin
            ken_n = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        ken_n = !ken_on;
        @(negedge clk);
        kind = $urandom_range(0, 2); // R10: single, burst or both
        rdy_n  = !(kind == 0 || kind == 2);
        brdy_n = !(kind == 1 || kind == 2);
        ken_n  = 1'($urandom_range(0, 1));
        @(negedge clk);
        rdy_n  = 1'b1;
        brdy_n = 1'b1;
    endtask

    task automatic do_read(input bit c, input bit kf, input bit kl, input bit pg,
                           input bit pwt, input bit pcd, input bit cd, input bit disturb);
        bit fill, epwt, epcd;
        fill = exp_cacheable(c, pg, pcd, cd) && kf;
        epwt = pg && pwt;
        epcd = pg && pcd && !cd;
        cyc_start = 1'b1; cyc_cacheable = c;
        paging_en = pg; page_pwt = pwt; page_pcd = pcd; cr_cd = cd;
        @(negedge clk);
        cyc_start = 1'b0;
        check("R5", pwt_o, epwt);
        check("R6", pcd_o, epcd);
        check("R1", line_fill, 1'b0);
        xfer(kf);
        check("R1/R4", line_fill, fill);
        if (fill) begin
            xfer(1'($urandom_range(0, 1)));
            if (disturb) begin
                cyc_start = 1'b1; paging_en = 1'b1; page_pwt = !epwt;
                page_pcd = 1'b1; cr_cd = 1'b0;
                @(negedge clk);
                cyc_start = 1'b0;
                @(negedge clk);
                check("R9 pwt", pwt_o, epwt);
                check("R9 pcd", pcd_o, epcd);
                check("R9 fill", line_fill, 1'b1);
            end
            for (int b = 2; b < 4 - 1; b++) xfer(1'($urandom_range(0, 1)));
            check("R2", line_fill, 1'b1);
            xfer(kl);
            check("R2", line_fill, 1'b0);
            check("R3", line_commit, kl);
            @(negedge clk);
            check("R3", line_commit, 1'b0);
        end else begin
            check("R3", line_commit, 1'b0);
            @(negedge clk);
            check("R3", line_commit, 1'b0);
        end
    endtask

    task automatic flush_test(input int low_len);
        int pulses;
        flush_n = 1'b0;
        for (int i = 1; i <= low_len + 3; i++) begin
            @(negedge clk);
            if (i == low_len) flush_n = 1'b1;
            if (i == 2) check("R8 pulse", flush_req, 1'b1);
            if (i == 1 || i == 3) check("R8 width", flush_req, 1'b0);
            if (flush_req) pulses++;
        end
        check("R8 count", 1'(pulses == 1), 1'b1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cyc_start = 0; cyc_cacheable = 0; ken_n = 1; rdy_n = 1; brdy_n = 1;
        paging_en = 0; page_pwt = 0; page_pcd = 0; cr_cd = 0; bus_hold = 0; flush_n = 1;
        repeat (3) @(negedge clk);
        check("R11 fill", line_fill, 1'b0);
        check("R11 commit", line_commit, 1'b0);
        check("R11 flush", flush_req, 1'b0);
        check("R11 pwt", pwt_o, 1'b0);
        check("R11 pcd", pcd_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        do_read(1, 1, 1, 1, 1, 0, 0, 1); // fill and commit, start ignored (R9)
        do_read(1, 1, 0, 0, 1, 1, 0, 0); // paging off: pcd ignored (R4), no commit
        do_read(1, 0, 1, 1, 0, 0, 0, 0); // enable off at first transfer
        do_read(0, 1, 1, 1, 1, 1, 1, 0); // not cacheable
        do_read(1, 1, 1, 1, 1, 0, 1, 0); // control disable (R4, R6)
        do_read(1, 1, 1, 1, 0, 1, 0, 0); // page disable (R4)
        do_read(1, 1, 1, 1, 1, 1, 1, 1); // pcd masked by cd (R6)

        // R7
        bus_hold = 1'b1; #1 check("R7", attr_oe, 1'b0);
        @(negedge clk); bus_hold = 1'b0; #1 check("R7", attr_oe, 1'b1);
        @(negedge clk);

        // R8
        flush_test(1);
        flush_test(5);

        // random mix
        for (int n = 0; n < 60; n++) begin
            do_read(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule